// File: doc/BRIEF.md
# Single-Cycle Byte Multiply-Accumulate Element

This element is the arithmetic core of one processing cell. Each clock it accepts two unsigned 8-bit operands and a 3-bit operation code. It can add, subtract, multiply, add an operand into a running total, multiply and add into that total, or clear the total. Every operation takes a single clock. Operands and code are captured in input registers, and the result leaves through an output register together with a valid strobe.

The 8x8 product is not made by one wide multiplier. Two 8x4 multipliers each take one 4-bit half of the second operand. Their partial products are merged by one shared three-input addition stage. The same stage also does addition, subtraction and accumulation, so no operation needs an adder of its own.

The running total is a 20-bit register. It is visible on its own port, so its state can be read after any operation.

Top module: `mac8_unit`

## Requirements
- R1: While reset (rstN low) is asserted, and after it is released, outValid is 0, outResult is 0 and outAcc is 0 until an operation completes.
- R2: An operation presented with inValid high is captured on one rising edge. Its result and a high outValid appear after the next rising edge. One new operation can be accepted on every clock.
- R3: Code 0 (add) gives outResult = inA + inB as a 9-bit unsigned sum, zero-extended, with the carry kept (255+255 = 510).
- R4: Code 1 (subtract) gives outResult = (inA - inB) mod 256, zero-extended (3 - 5 = 254).
- R5: Code 3 (multiply) gives outResult = inA * inB as a 16-bit unsigned product (255*255 = 65025).
- R6: Code 2 (accumulate) sets the total to total + inA. outResult shows the low 16 bits of the new total.
- R7: Code 4 (multiply-accumulate) sets the total to total + inA*inB. outResult shows the low 16 bits of the new total.
- R8: The total wraps modulo 2^20.
- R9: Code 5 (clear) sets the total to 0 and gives outResult = 0 with outValid high.
- R10: Codes 6 and 7 have no effect: outValid stays low, and outResult and outAcc keep their values. The same holds for any cycle with inValid low.
- R11: Add, subtract and multiply leave the total unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| inOp | input | 3 | Operation code (0 add, 1 sub, 2 acc, 3 mul, 4 mac, 5 clear) |
| inA | input | 8 | First operand, unsigned |
| inB | input | 8 | Second operand, unsigned |
| outValid | output | 1 | Result register holds a new result |
| outResult | output | 16 | Registered result |
| outAcc | output | 20 | Current running total |

## Verification
The bench multiplies operands with both nibbles of inB set (for example 255*255 and 0xA7*0x5C). A design that drops the shift on the upper partial product, or mixes up the halves, returns a wrong product there.

It subtracts a larger number from a smaller one and adds two 255s. A design that forgets the carry-in, or truncates the add, shows 253 or 254 instead of the expected values.

Seventeen full-scale multiply-accumulates push the total past 2^20 to check the wrap. Back-to-back codes check that results are not held or repeated. Unused codes with non-zero operands are issued, and outAcc and outResult must stay frozen; a decoder that treated them as accumulate or clear would move these outputs.

// File: rtl/mac8_pkg.sv
package mac8_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_ACCUM = 3'd2,
    OP_MUL   = 3'd3,
    OP_MAC   = 3'd4,
    OP_CLEAR = 3'd5
  } opcode_e;

  // Strobes from control to datapath for the operation held in the input registers
  typedef struct packed {
    logic fire;    // a defined operation is present
    logic usePp;   // feed the two partial products into the adder
    logic useB;    // feed operand B (or its inverse) into the adder
    logic invB;    // invert B and add a carry-in (subtract)
    logic useAcc;  // feed the running total into the adder
    logic trunc8;  // keep only the low byte of the sum
    logic wrAcc;   // write the sum back into the total
    logic clrAcc;  // zero the total
  } ctrlStrobes_t;

endpackage

// File: rtl/mac8_ctrl.sv
module mac8_ctrl
  import mac8_pkg::*;
#(
  parameter int OP_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] inOp,
  output ctrlStrobes_t    strb
);

  logic            vReg;
  logic [OP_W-1:0] opReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vReg  <= 1'b0;
      opReg <= '0;
    end else begin
      vReg  <= inValid;
      opReg <= inOp;
    end
  end

  always_comb begin
    strb = '0;
    case (opReg)
      OP_W'(OP_ADD):   begin strb.fire = vReg; strb.useB = 1'b1; end
      OP_W'(OP_SUB):   begin strb.fire = vReg; strb.useB = 1'b1; strb.invB = 1'b1; strb.trunc8 = 1'b1; end
      OP_W'(OP_ACCUM): begin strb.fire = vReg; strb.useAcc = 1'b1; strb.wrAcc = vReg; end
      OP_W'(OP_MUL):   begin strb.fire = vReg; strb.usePp = 1'b1; end
      OP_W'(OP_MAC):   begin strb.fire = vReg; strb.usePp = 1'b1; strb.useAcc = 1'b1; strb.wrAcc = vReg; end
      OP_W'(OP_CLEAR): begin strb.fire = vReg; strb.clrAcc = vReg; end
      default:         strb = '0;
    endcase
  end

endmodule

// File: rtl/mac8_datapath.sv
module mac8_datapath
  import mac8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  ctrlStrobes_t      strb,
  output logic              outValid,
  output logic [2*DATA_W-1:0] outResult,
  output logic [ACC_W-1:0]  outAcc
);

  localparam int HALF   = DATA_W / 2;
  localparam int HALVES = 2;
  localparam int PP_W   = DATA_W + HALF;
  localparam int RES_W  = 2 * DATA_W;

  logic [DATA_W-1:0] aReg, bReg;
  logic [ACC_W-1:0]  accReg;
  logic [PP_W-1:0]   pp [HALVES];
  logic [ACC_W-1:0]  opndX, opndY, opndZ, sumW;
  logic [RES_W-1:0]  resNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
    end else begin
      aReg <= inA;
      bReg <= inB;
    end
  end

  // One narrow multiplier per half of operand B
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign pp[h] = PP_W'(aReg) * PP_W'(bReg[h*HALF +: HALF]);
  end

  // Shared three-input addition stage
  always_comb begin
    opndX = strb.usePp ? ACC_W'(pp[0]) : ACC_W'(aReg);
    if (strb.usePp)     opndY = ACC_W'(pp[1]) << HALF;
    else if (strb.useB) opndY = ACC_W'(strb.invB ? ~bReg : bReg);
    else                opndY = '0;
    opndZ   = strb.useAcc ? accReg : '0;
    sumW    = opndX + opndY + opndZ + ACC_W'(strb.invB);
    resNext = strb.trunc8 ? RES_W'(sumW[DATA_W-1:0]) : sumW[RES_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg    <= '0;
      outValid  <= 1'b0;
      outResult <= '0;
    end else begin
      outValid <= strb.fire;
      if (strb.clrAcc)     accReg <= '0;
      else if (strb.wrAcc) accReg <= sumW;
      if (strb.clrAcc)     outResult <= '0;
      else if (strb.fire)  outResult <= resNext;
    end
  end

  assign outAcc = accReg;

endmodule

// File: rtl/mac8_unit.sv
module mac8_unit
  import mac8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 20,
  parameter int OP_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [OP_W-1:0]     inOp,
  input  logic [DATA_W-1:0]   inA,
  input  logic [DATA_W-1:0]   inB,
  output logic                outValid,
  output logic [2*DATA_W-1:0] outResult,
  output logic [ACC_W-1:0]    outAcc
);

  ctrlStrobes_t strb;

  mac8_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .strb(strb)
  );

  mac8_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .inA(inA), .inB(inB), .strb(strb),
    .outValid(outValid), .outResult(outResult), .outAcc(outAcc)
  );

endmodule

// File: rtl/mac8_unit_chk.sv
module mac8_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [2:0]  inOp,
  input logic [7:0]  inA,
  input logic [7:0]  inB,
  input logic        outValid,
  input logic [15:0] outResult,
  input logic [19:0] outAcc
);

  logic [1:0] upCnt;
  logic       armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          upCnt <= '0;
    else if (upCnt < 2) upCnt <= upCnt + 2'd1;
  end
  assign armed = (upCnt == 2'd2);

  // R3
  a_r3_add_sum: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(inValid && inOp == 3'd0, 2) |->
      outValid && outResult == 16'($past(inA, 2)) + 16'($past(inB, 2)));

  // R4
  a_r4_sub_wrap: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(inValid && inOp == 3'd1, 2) |->
      outValid && outResult == {8'd0, 8'($past(inA, 2) - $past(inB, 2))});

  // R5
  a_r5_mul_product: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(inValid && inOp == 3'd3, 2) |->
      outValid && outResult == 16'($past(inA, 2)) * 16'($past(inB, 2)));

  // R9
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(inValid && inOp == 3'd5, 2) |->
      outValid && outResult == 16'd0 && outAcc == 20'd0);

  // R10
  a_r10_noop_frozen: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(!inValid || inOp > 3'd5, 2) |->
      !outValid && $stable(outAcc) && $stable(outResult));

  // R11
  a_r11_acc_kept: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(inValid && (inOp == 3'd0 || inOp == 3'd1 || inOp == 3'd3), 2) |->
      $stable(outAcc));

endmodule

bind mac8_unit mac8_unit_chk u_chk (.*);

// File: tb/mac8_unit_bench.sv
module mac8_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  inOp = '0;
  logic [7:0]  inA = '0;
  logic [7:0]  inB = '0;
  logic        outValid;
  logic [15:0] outResult;
  logic [19:0] outAcc;

  int checks = 0;
  int failures = 0;
  logic [19:0] expAcc = '0;

  always #10 clk = ~clk;  // 50 MHz

  mac8_unit u_mac8_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inA(inA), .inB(inB),
    .outValid(outValid), .outResult(outResult), .outAcc(outAcc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one operation at a falling edge; sample two falling edges later
  task automatic runOp(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1; inOp = op; inA = a; inB = b;
    @(negedge clk);
    inValid = 1'b0; inOp = '0; inA = '0; inB = '0;
    @(negedge clk);
  endtask

  task automatic tReset();
    chk("R1 valid", 32'(outValid), 0);
    chk("R1 result", 32'(outResult), 0);
    chk("R1 acc", 32'(outAcc), 0);
  endtask

  task automatic tAddSub();
    runOp(3'd0, 8'd255, 8'd255);
    chk("R3 add carry", 32'(outResult), 510);
    chk("R2 valid", 32'(outValid), 1);
    chk("R11 acc after add", 32'(outAcc), 32'(expAcc));
    runOp(3'd0, 8'd17, 8'd25);
    chk("R3 add", 32'(outResult), 42);
    runOp(3'd1, 8'd3, 8'd5);
    chk("R4 sub wrap", 32'(outResult), 254);
    runOp(3'd1, 8'd200, 8'd55);
    chk("R4 sub", 32'(outResult), 145);
    chk("R11 acc after sub", 32'(outAcc), 32'(expAcc));
  endtask

  task automatic tMul();
    runOp(3'd3, 8'd255, 8'd255);
    chk("R5 mul max", 32'(outResult), 65025);
    runOp(3'd3, 8'hA7, 8'h5C);
    chk("R5 mul mixed", 32'(outResult), 167 * 92);
    runOp(3'd3, 8'd9, 8'h10);
    chk("R5 mul upper nibble", 32'(outResult), 144);
    chk("R11 acc after mul", 32'(outAcc), 32'(expAcc));
  endtask

  task automatic tAccum();
    runOp(3'd2, 8'd100, 8'd77);
    expAcc = expAcc + 20'd100;
    chk("R6 acc total", 32'(outAcc), 32'(expAcc));
    runOp(3'd2, 8'd250, 8'd0);
    expAcc = expAcc + 20'd250;
    chk("R6 acc result", 32'(outResult), 32'(expAcc[15:0]));
    runOp(3'd4, 8'd12, 8'd13);
    expAcc = expAcc + 20'd156;
    chk("R7 mac total", 32'(outAcc), 32'(expAcc));
    chk("R7 mac result", 32'(outResult), 32'(expAcc[15:0]));
  endtask

  task automatic tClear();
    runOp(3'd5, 8'd44, 8'd55);
    expAcc = '0;
    chk("R9 clear acc", 32'(outAcc), 0);
    chk("R9 clear result", 32'(outResult), 0);
    chk("R9 clear valid", 32'(outValid), 1);
  endtask

  task automatic tWrap();
    for (int i = 0; i < 17; i++) begin
      runOp(3'd4, 8'd255, 8'd255);
      expAcc = expAcc + 20'd65025;
      if (i == 15) chk("R7 mac 16th low word", 32'(outResult), 57360);
    end
    chk("R8 wrap total", 32'(outAcc), 56849);
    chk("R8 wrap result", 32'(outResult), 56849);
  endtask

  task automatic tNoop();
    logic [15:0] prevRes;
    logic [19:0] prevAcc;
    prevRes = outResult;
    prevAcc = outAcc;
    runOp(3'd6, 8'd99, 8'd99);
    chk("R10 code6 valid", 32'(outValid), 0);
    chk("R10 code6 acc", 32'(outAcc), 32'(prevAcc));
    chk("R10 code6 result", 32'(outResult), 32'(prevRes));
    runOp(3'd7, 8'd255, 8'd1);
    chk("R10 code7 acc", 32'(outAcc), 32'(prevAcc));
    chk("R10 code7 result", 32'(outResult), 32'(prevRes));
    @(negedge clk);
    inValid = 1'b0; inOp = 3'd5; inA = 8'd1; inB = 8'd1;
    @(negedge clk);
    @(negedge clk);
    inOp = '0; inA = '0; inB = '0;
    chk("R10 invalid clear ignored", 32'(outAcc), 32'(prevAcc));
    chk("R10 invalid valid low", 32'(outValid), 0);
  endtask

  task automatic tBackToBack();
    @(negedge clk);
    inValid = 1'b1; inOp = 3'd3; inA = 8'd20; inB = 8'd30;
    @(negedge clk);
    inOp = 3'd0; inA = 8'd1; inB = 8'd2;
    @(negedge clk);
    chk("R2 b2b mul", 32'(outResult), 600);
    inOp = 3'd1; inA = 8'd0; inB = 8'd1;
    @(negedge clk);
    chk("R2 b2b add", 32'(outResult), 3);
    inValid = 1'b0; inOp = '0; inA = '0; inB = '0;
    @(negedge clk);
    chk("R2 b2b sub", 32'(outResult), 255);
    chk("R2 b2b valid", 32'(outValid), 1);
    @(negedge clk);
    chk("R2 b2b drop", 32'(outValid), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAddSub();
    tMul();
    tAccum();
    tClear();
    tWrap();
    tNoop();
    tBackToBack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule